// File: doc/BRIEF.md
# 64-bit Integer Multiply and Multiply-Add Unit

This block is a multi-cycle integer multiplier for a 64-bit datapath. A single 64x64 shift-add engine builds a 128-bit product. A final stage corrects the sign, optionally adds a third operand, and picks the half of the 128-bit value that the requested form returns. It covers the following forms:

- low and high doubleword multiply, with the high form in signed and unsigned variants;
- low and high word multiply, using only the lower 32 bits of each operand;
- multiply-add in high-signed, high-unsigned and low variants.

A caller pulses `start` with an operation code, the operands and the record and overflow-enable controls. The unit captures all of them on that edge. After a fixed number of cycles it returns the result and a one-cycle `done` pulse. With the same pulse it returns a condition nibble, overflow and summary-overflow bits, and write enables that tell the surrounding core which status to update. Only one operation is in flight at a time.

Top module: `mac64_unit`

## Requirements
- R1: A `start` seen while idle captures `op`, `a`, `b`, `c`, `rec`, `oe` and `so_in`. `done` is high for exactly one cycle, LATENCY = 64/STEP + 1 rising edges after the capturing edge (9 with STEP=8). `result` and the status outputs are valid in that cycle. Later changes to the inputs have no effect on them.
- R2: Op code 0 (low doubleword) returns bits 63:0 of A*B. Codes 9 to 15 behave as code 0.
- R3: Op codes 1 and 2 return bits 127:64 of the 128-bit product. Code 1 treats A and B as signed and code 2 as unsigned.
- R4: Op code 3 (low word) multiplies the signed lower 32 bits of A and B and returns the full signed 64-bit product. Bits 63:32 of the operands have no effect.
- R5: Op codes 4 (signed) and 5 (unsigned) return, in `result[31:0]`, bits 63:32 of the 64-bit product of the lower operand words. `result[63:32]` is unspecified.
- R6: Op codes 6 (signed high), 7 (unsigned high) and 8 (low) form A*B + C over 128 bits. C is sign-extended for codes 6 and 8 and zero-extended for code 7. Codes 6 and 7 return bits 127:64 of the sum and code 8 returns bits 63:0.
- R7: Multiply-add forms (codes 6 to 8) never assert `cr_we` or `ov_we`, whatever `rec` and `oe` are.
- R8: For codes 0 to 5, `cr_we` pulses with `done` exactly when `rec` was 1. The nibble `cr` is {lt, gt, eq, so}, bit 3 first, from a signed compare of `result` with zero. Bit 0 is the summary-overflow value after this operation. For codes 4 and 5 only bit 0 is defined.
- R9: For codes 0 and 3 with `oe`=1, `ov_we` pulses with `done`. Code 0 sets `ov` and `ov32` when the signed 128-bit product does not fit in 64 bits. Code 3 sets them when the signed 64-bit product does not fit in 32 bits. `so` = `so_in` OR `ov`.
- R10: High multiply forms (codes 1, 2, 4, 5) never assert `ov_we`.
- R11: A `start` while an operation is running is ignored: no extra `done`, and the running result is unchanged.
- R12: After reset, `done`, `cr_we` and `ov_we` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op | input | 4 | Operation code, see R2 to R6 |
| a | input | 64 | Multiplicand |
| b | input | 64 | Multiplier |
| c | input | 64 | Addend for multiply-add forms |
| rec | input | 1 | Request a condition nibble update |
| oe | input | 1 | Request an overflow update |
| so_in | input | 1 | Current summary-overflow bit |
| result | output | 64 | Selected half of product or sum |
| done | output | 1 | One-cycle completion pulse |
| cr | output | 4 | {lt, gt, eq, so} of the result |
| cr_we | output | 1 | Condition nibble write enable |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | 32-bit overflow |
| so | output | 1 | Updated summary overflow |
| ov_we | output | 1 | Overflow bits write enable |

## Verification
Every result, status bit and write enable appears in one cycle only: the cycle after the ninth rising edge that follows the capturing edge. Before that edge nothing is valid, and after it `done` has already fallen. The bench drives `start` on a falling edge and then counts falling edges. At each one it compares `done` with the expected schedule, low for the first eight and high on the ninth. It compares data and status only on the ninth, and confirms on the tenth that `done` has dropped. Bits that a form leaves unspecified are masked out of the comparison.

// File: rtl/mac64_pkg.sv
package mac64_pkg;

  typedef enum logic [3:0] {
    OP_MUL_LO    = 4'd0,
    OP_MUL_HI_S  = 4'd1,
    OP_MUL_HI_U  = 4'd2,
    OP_MULW_LO   = 4'd3,
    OP_MULW_HI_S = 4'd4,
    OP_MULW_HI_U = 4'd5,
    OP_MAC_HI_S  = 4'd6,
    OP_MAC_HI_U  = 4'd7,
    OP_MAC_LO    = 4'd8
  } mac_op_e;

  function automatic logic op_signed(mac_op_e o);
    return !(o == OP_MUL_HI_U || o == OP_MULW_HI_U || o == OP_MAC_HI_U);
  endfunction

  function automatic logic op_word(mac_op_e o);
    return (o == OP_MULW_LO || o == OP_MULW_HI_S || o == OP_MULW_HI_U);
  endfunction

  function automatic logic op_mac(mac_op_e o);
    return (o == OP_MAC_HI_S || o == OP_MAC_HI_U || o == OP_MAC_LO);
  endfunction

  function automatic logic op_high(mac_op_e o);
    return (o == OP_MUL_HI_S || o == OP_MUL_HI_U ||
            o == OP_MULW_HI_S || o == OP_MULW_HI_U);
  endfunction

endpackage

// File: rtl/mac64_iter.sv
module mac64_iter #(
  parameter int W    = 64,
  parameter int STEP = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  output logic [2*W-1:0] prod,
  output logic           fin
);
  localparam int ITER = W / STEP;
  localparam int CW   = $clog2(ITER + 1);

  logic [W-1:0]      hi_q, lo_q, ma_q;
  logic [CW-1:0]     cnt_q;
  logic              fin_q;
  logic [W+STEP-1:0] digit_prod, acc_sum;
  logic [2*W-1:0]    shifted;

  always_comb begin
    digit_prod = {{STEP{1'b0}}, ma_q} * {{W{1'b0}}, lo_q[STEP-1:0]};
    acc_sum    = {{STEP{1'b0}}, hi_q} + digit_prod;
    shifted    = {acc_sum, lo_q[W-1:STEP]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= '0;
      lo_q  <= '0;
      ma_q  <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= (cnt_q == CW'(1));
      if (load) begin
        hi_q  <= '0;
        lo_q  <= mag_b;
        ma_q  <= mag_a;
        cnt_q <= CW'(ITER);
      end else if (cnt_q != '0) begin
        hi_q  <= shifted[2*W-1:W];
        lo_q  <= shifted[W-1:0];
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign prod = {hi_q, lo_q};
  assign fin  = fin_q;
endmodule

// File: rtl/mac64_flags.sv
module mac64_flags
  import mac64_pkg::*;
#(
  parameter int W = 64
) (
  input  mac_op_e            op,
  input  logic [2*W-W/2:0]   ov_src,
  input  logic [W-1:0]       res,
  input  logic               rec,
  input  logic               oe,
  input  logic               so_in,
  output logic [3:0]         cr,
  output logic               cr_we,
  output logic               ov,
  output logic               ov32,
  output logic               so,
  output logic               ov_we
);
  localparam int H = W / 2;

  logic ovf, lt, eq;

  always_comb begin
    ovf = 1'b0;
    if (op == OP_MUL_LO)
      ovf = ov_src[2*W-H:W-H] != {(W+1){ov_src[W-H]}};
    else if (op == OP_MULW_LO)
      ovf = ov_src[W-H:0] != {(H+1){ov_src[0]}};
    ov_we = oe && (op == OP_MUL_LO || op == OP_MULW_LO);
    ov    = ovf;
    ov32  = ovf;
    so    = so_in | (ov_we & ovf);
    cr_we = rec && !op_mac(op);
    lt    = res[W-1];
    eq    = (res == '0);
    cr    = {lt, !lt && !eq, eq, so};
  end
endmodule

// File: rtl/mac64_unit.sv
module mac64_unit
  import mac64_pkg::*;
#(
  parameter int W    = 64,
  parameter int STEP = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic         rec,
  input  logic         oe,
  input  logic         so_in,
  output logic [W-1:0] result,
  output logic         done,
  output logic [3:0]   cr,
  output logic         cr_we,
  output logic         ov,
  output logic         ov32,
  output logic         so,
  output logic         ov_we
);
  localparam int H = W / 2;

  mac_op_e        op_in, op_q;
  logic           busy_q, neg_q, rec_q, oe_q, so_q;
  logic [W-1:0]   c_q;
  logic           accept, sgn, wrd, fin;
  logic [W-1:0]   ea, eb, mag_a, mag_b;
  logic [2*W-1:0] prod, fixed, cext, wide;
  logic [W-1:0]   res_c;
  logic [3:0]     cr_c;
  logic           cr_we_c, ov_c, ov32_c, so_c, ov_we_c;

  assign op_in  = (op > 4'd8) ? OP_MUL_LO : mac_op_e'(op);
  assign accept = start && !busy_q;

  always_comb begin
    sgn = op_signed(op_in);
    wrd = op_word(op_in);
    ea  = wrd ? {{H{sgn & a[H-1]}}, a[H-1:0]} : a;
    eb  = wrd ? {{H{sgn & b[H-1]}}, b[H-1:0]} : b;
    mag_a = (sgn && ea[W-1]) ? -ea : ea;
    mag_b = (sgn && eb[W-1]) ? -eb : eb;
  end

  mac64_iter #(.W(W), .STEP(STEP)) u_iter (
    .clk(clk), .rst(rst), .load(accept),
    .mag_a(mag_a), .mag_b(mag_b), .prod(prod), .fin(fin)
  );

  always_comb begin
    fixed = neg_q ? -prod : prod;
    cext  = {{W{c_q[W-1] & op_signed(op_q)}}, c_q};
    wide  = op_mac(op_q) ? fixed + cext : fixed;
    unique case (op_q)
      OP_MUL_HI_S, OP_MUL_HI_U,
      OP_MAC_HI_S, OP_MAC_HI_U:   res_c = wide[2*W-1:W];
      OP_MULW_HI_S, OP_MULW_HI_U: res_c = {wide[W-1:H], wide[W-1:H]};
      default:                    res_c = wide[W-1:0];
    endcase
  end

  mac64_flags #(.W(W)) u_flags (
    .op(op_q), .ov_src(wide[2*W-1:H-1]), .res(res_c),
    .rec(rec_q), .oe(oe_q), .so_in(so_q),
    .cr(cr_c), .cr_we(cr_we_c), .ov(ov_c), .ov32(ov32_c),
    .so(so_c), .ov_we(ov_we_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      op_q   <= OP_MUL_LO;
      neg_q  <= 1'b0;
      rec_q  <= 1'b0;
      oe_q   <= 1'b0;
      so_q   <= 1'b0;
      c_q    <= '0;
      result <= '0;
      done   <= 1'b0;
      cr     <= '0;
      cr_we  <= 1'b0;
      ov     <= 1'b0;
      ov32   <= 1'b0;
      so     <= 1'b0;
      ov_we  <= 1'b0;
    end else begin
      done  <= fin;
      cr_we <= fin & cr_we_c;
      ov_we <= fin & ov_we_c;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= op_in;
        neg_q  <= sgn & (ea[W-1] ^ eb[W-1]);
        rec_q  <= rec;
        oe_q   <= oe;
        so_q   <= so_in;
        c_q    <= c;
      end else if (fin) begin
        busy_q <= 1'b0;
        result <= res_c;
        cr     <= cr_c;
        ov     <= ov_c;
        ov32   <= ov32_c;
        so     <= so_c;
      end
    end
  end
endmodule

// File: rtl/mac64_chk.sv
module mac64_chk
  import mac64_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    start,
  input logic    busy,
  input mac_op_e op_q,
  input logic    done,
  input logic    cr_we,
  input logic    ov_we,
  input logic    ov,
  input logic    so
);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_hold_op_r11: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(op_q));

  p_mac_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (done && op_mac(op_q)) |-> (!cr_we && !ov_we));

  p_we_done_r8: assert property (@(posedge clk) disable iff (rst)
    (cr_we || ov_we) |-> done);

  p_sticky_so_r9: assert property (@(posedge clk) disable iff (rst)
    (ov_we && ov) |-> so);

  p_no_ov_high_r10: assert property (@(posedge clk) disable iff (rst)
    (done && op_high(op_q)) |-> !ov_we);
endmodule

bind mac64_unit mac64_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy_q), .op_q(op_q),
  .done(done), .cr_we(cr_we), .ov_we(ov_we), .ov(ov), .so(so)
);

// File: tb/sim_mac64_unit.sv
module sim_mac64_unit;
  localparam int W   = 64;
  localparam int LAT = 64 / 8 + 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [3:0] op = '0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic rec = 1'b0, oe = 1'b0, so_in = 1'b0;
  logic [W-1:0] result;
  logic done, cr_we, ov, ov32, so, ov_we;
  logic [3:0] cr;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  mac64_unit #(.W(W), .STEP(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b), .c(c),
    .rec(rec), .oe(oe), .so_in(so_in), .result(result), .done(done),
    .cr(cr), .cr_we(cr_we), .ov(ov), .ov32(ov32), .so(so), .ov_we(ov_we)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [W-1:0] xa,
                        input logic [W-1:0] xb, input logic [W-1:0] xc,
                        input logic xr, input logic xoe, input logic xso,
                        input logic intrude);
    logic [3:0] eo;
    logic sg, wd, mc, hi, hw;
    logic [127:0] pa, pb, p, s;
    logic [W-1:0] er, mask;
    logic e_ovf, e_crwe, e_ovwe, e_so;
    logic [3:0] e_cr, crmask;
    eo = (o > 4'd8) ? 4'd0 : o;
    sg = !(eo == 2 || eo == 5 || eo == 7);
    wd = (eo >= 3 && eo <= 5);
    mc = (eo >= 6);
    hi = (eo == 1 || eo == 2 || eo == 6 || eo == 7);
    hw = (eo == 4 || eo == 5);
    if (wd) begin
      pa = sg ? 128'($signed(xa[31:0])) : {96'd0, xa[31:0]};
      pb = sg ? 128'($signed(xb[31:0])) : {96'd0, xb[31:0]};
    end else begin
      pa = sg ? 128'($signed(xa)) : {64'd0, xa};
      pb = sg ? 128'($signed(xb)) : {64'd0, xb};
    end
    p = pa * pb;
    s = mc ? p + (sg ? 128'($signed(xc)) : {64'd0, xc}) : p;
    if (hi) er = s[127:64];
    else if (hw) er = {32'd0, p[63:32]};
    else er = s[63:0];
    mask = hw ? 64'h0000_0000_FFFF_FFFF : '1;
    if (eo == 0) e_ovf = ($signed(p) > 128'sh7FFF_FFFF_FFFF_FFFF) ||
                         ($signed(p) < -128'sh8000_0000_0000_0000);
    else if (eo == 3) e_ovf = ($signed(p) > 128'sh7FFF_FFFF) ||
                              ($signed(p) < -128'sh8000_0000);
    else e_ovf = 1'b0;
    e_ovwe = xoe && (eo == 0 || eo == 3);
    e_crwe = xr && !mc;
    e_so   = xso | (e_ovwe & e_ovf);
    e_cr   = {$signed(er) < 0, $signed(er) > 0, er == 0, e_so};
    crmask = hw ? 4'b0001 : 4'b1111;

    @(negedge clk);
    op = o; a = xa; b = xb; c = xc; rec = xr; oe = xoe; so_in = xso;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~xa; b = xb ^ 64'h5A5A; c = ~xc; rec = ~xr; oe = ~xoe; so_in = ~xso;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge clk);
      if (intrude && k == 2) begin
        start = 1'b1; op = 4'd1; a = 64'd7; b = 64'd9;
      end else begin
        start = 1'b0;
      end
      chk(done == (k == LAT), "R1 done timing", {63'd0, done}, {63'd0, k == LAT});
      if (k == LAT) begin
        chk((result & mask) == (er & mask),
            hw ? "R5 high word" : mc ? "R6 multiply-add" : wd ? "R4 low word" :
            hi ? "R3 high dword" : "R2 low dword", result & mask, er & mask);
        chk(cr_we == e_crwe, mc ? "R7 mac cr_we" : "R8 cr_we",
            {63'd0, cr_we}, {63'd0, e_crwe});
        chk(ov_we == e_ovwe, mc ? "R7 mac ov_we" : hi || hw ? "R10 ov_we" : "R9 ov_we",
            {63'd0, ov_we}, {63'd0, e_ovwe});
        if (e_crwe)
          chk((cr & crmask) == (e_cr & crmask), "R8 cr nibble",
              {60'd0, cr & crmask}, {60'd0, e_cr & crmask});
        if (e_ovwe)
          chk(ov == e_ovf && ov32 == e_ovf && so == e_so, "R9 ov/ov32/so",
              {61'd0, ov, ov32, so}, {61'd0, e_ovf, e_ovf, e_so});
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, intrude ? "R11 no extra done" : "R1 single pulse",
        {63'd0, done}, 64'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(done == 0 && cr_we == 0 && ov_we == 0, "R12 reset strobes",
        {61'd0, done, cr_we, ov_we}, 64'd0);
    chk(result == '0, "R12 reset result", result, 64'd0);

    run_op(4'd0, 64'd3, 64'd5, 64'd0, 1, 1, 0, 0);                         // R2
    run_op(4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd2, 0, 1, 1, 0, 0);           // R9 overflow
    run_op(4'd0, '1, '1, 0, 1, 1, 1, 0);                                    // R9 sticky so
    run_op(4'd12, 64'hFFFF_FFFF_0000_0001, 64'h10, 0, 1, 0, 0, 0);         // R2 reserved code
    run_op(4'd1, '1, '1, 0, 1, 1, 0, 0);                                    // R3, R10
    run_op(4'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1, 0, 0, 0);
    run_op(4'd2, '1, '1, 0, 1, 1, 0, 0);                                    // R3 unsigned
    run_op(4'd3, 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_0000_0000_0003, 0, 1, 1, 0, 0); // R4
    run_op(4'd3, 64'h7FFF_FFFF, 64'd2, 0, 1, 1, 0, 0);                     // R4, R9 ov32
    run_op(4'd4, 64'hFFFF_FFFE, 64'h3, 0, 1, 1, 0, 0);                     // R5 signed
    run_op(4'd5, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0, 1, 1, 1, 0);             // R5 unsigned
    run_op(4'd6, '1, 64'd1, '1, 1, 1, 0, 0);                                // R6, R7
    run_op(4'd7, '1, '1, '1, 1, 1, 0, 0);                                   // R6 unsigned
    run_op(4'd8, 64'h1234_5678_9ABC_DEF0, 64'd3, 64'h8000_0000_0000_0000, 1, 1, 0, 0);
    run_op(4'd0, 64'd11, 64'd13, 0, 0, 0, 0, 1);                            // R11
    for (int i = 0; i < 40; i++)
      run_op(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, 1'($urandom), 1'($urandom), 1'($urandom),
             (i % 5) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule